// File: doc/BRIEF.md
# Single-Shot Comparator Status Bank

This block holds a small bank of one-shot match controls for a trace unit. Each control unit watches the pulses of a set of address comparators, reduced through a per-unit selection mask. On a hit it records a sticky status flag and drives a one-cycle fire pulse. A per-unit restart bit sets the mode. With the bit clear, the unit fires once and then stays disarmed until software clears its status. With the bit set, every later hit fires again.

A hit that lands while the shared resources are paused does not fire. It sets a sticky pending flag instead. A single deferred fire pulse follows in the cycle after the pause is lifted. Software sees each unit as a 64-bit word, reached through a simple indexed read/write port. The word carries the status and pending flags plus fixed capability bits. Writes count only while the trace unit is Idle. Reads return data only while the trace unit is Idle or Stable.

Top module: `oneshot_status_bank`

## Requirements
- R1: A hit on any comparator whose bit is set in the unit's selection mask sets that unit's status; hits on unselected comparators leave the unit untouched and do not fire it.
- R2: Once set, status stays 1 through any number of idle cycles and further hits until a valid write changes it.
- R3: With restart clear, the first hit fires once; while status is 1, later hits produce no fire pulse.
- R4: With restart set, every hit outside a pause drives `fire` high for exactly one cycle, in the cycle after the hit.
- R5: A hit while `paused` is 1 (and the unit armed) sets both status and pending and produces no fire pulse.
- R6: When `paused` falls with pending set, exactly one fire pulse appears in the cycle after the falling edge.
- R7: The read word holds status at bit 31 and pending at bit 30. Bit 3 is the unit's bit of the PE-comparator-support parameter. Bits 2 and 1 read 0 and bit 0 reads 1. All other bits read 0.
- R8: A write in Idle (`tu_state` 2'b00) to a valid index loads status from data bit 31 and pending from bit 30. Capability bits are unchanged, and a write overrides a hit in the same cycle.
- R9: Writes are ignored when `tu_state` is not Idle, and when the index is not below NUM_UNITS.
- R10: `reg_rdata` is zero unless `reg_rd` is 1, the index is valid, and `tu_state` is Idle (2'b00) or Stable (2'b01).
- R11: Synchronous active-low reset clears status, pending and fire in every unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_match | input | NUM_CMP | Comparator hit pulses |
| cmp_select | input | NUM_UNITS*NUM_CMP | Per-unit comparator selection masks, unit i in slice i |
| paused | input | 1 | Resources are paused |
| restart_en | input | NUM_UNITS | Per-unit re-fire enable |
| tu_state | input | 2 | Trace unit state: 00 Idle, 01 Stable, others busy |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_idx | input | 3 | Unit index for access |
| reg_wdata | input | 64 | Write data |
| fire | output | NUM_UNITS | Per-unit one-cycle fire pulses |
| reg_rdata | output | 64 | Status word of the addressed unit |

## Verification
The hardest case to reach is the deferred fire. It needs an armed unit, a hit that arrives while paused, a second hit that must be swallowed, and only then the release of the pause. The bench builds this in sequence and samples `fire` on the two cycles after the release. A second hard case is a write and a hit landing on the same edge. The bench drives both in one cycle and checks that the write wins. The selection logic is swept across every single-comparator pulse, with an overlapping mask on each unit.

// File: rtl/oss_pkg.sv
// Shared definitions for the one-shot status bank.
// Assumes the index port is 3 bits wide, so at most 8 units.
package oss_pkg;

    typedef enum logic [1:0] {
        TU_IDLE   = 2'b00,
        TU_STABLE = 2'b01,
        TU_BUSY   = 2'b10,
        TU_OTHER  = 2'b11
    } tu_state_e;

    localparam int WORD_W   = 64;
    localparam int BIT_STAT = 31;
    localparam int BIT_PEND = 30;
    localparam int BIT_PE   = 3;
    localparam int BIT_IA   = 0;

    // Assemble the software-visible word from the live flags and the capability.
    function automatic logic [WORD_W-1:0] build_word(input logic st, input logic pd,
                                                     input logic pe);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[BIT_STAT] = st;
        w[BIT_PEND] = pd;
        w[BIT_PE]   = pe;
        w[BIT_IA]   = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/oss_access_decode.sv
// Decodes the indexed register port into per-unit write enables and a read gate.
// Assumes NUM_UNITS is 1..8; indices at or above NUM_UNITS are treated as absent.
module oss_access_decode
    import oss_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [2:0]           reg_idx,
    input  logic [1:0]           tu_state,
    output logic [NUM_UNITS-1:0] wr_vec,
    output logic                 rd_ok
);
    localparam logic [3:0] IDX_LIM = 4'(NUM_UNITS);

    logic idx_ok;
    logic wr_ok;

    // Qualify the access by index range and trace unit state.
    always_comb begin
        idx_ok = {1'b0, reg_idx} < IDX_LIM;
        wr_ok  = reg_wr && idx_ok && (tu_state == TU_IDLE);
        rd_ok  = reg_rd && idx_ok &&
                 ((tu_state == TU_IDLE) || (tu_state == TU_STABLE));
    end

    generate
        for (genvar i = 0; i < NUM_UNITS; i++) begin : g_wr
            localparam logic [2:0] ID = 3'(i);
            // One enable per unit, raised only on a matching index.
            always_comb wr_vec[i] = wr_ok && (reg_idx == ID);
        end
    endgenerate

    assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec != '0) |-> (reg_wr && tu_state == TU_IDLE && {1'b0, reg_idx} < IDX_LIM));
    assert_write_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

endmodule

// File: rtl/oss_unit.sv
// One single-shot control: reduces selected comparator hits, keeps sticky
// status and pending flags, and produces a registered one-cycle fire pulse.
// Assumes cmp_match carries single-cycle pulses; a held hit re-fires each cycle
// when restart_en is set.
module oss_unit #(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_match,
    input  logic [NUM_CMP-1:0] cmp_sel,
    input  logic               paused,
    input  logic               restart_en,
    input  logic               wr_en,
    input  logic               wr_status,
    input  logic               wr_pending,
    output logic               status,
    output logic               pending,
    output logic               fire
);
    logic status_q, pending_q, fire_q, paused_q;
    logic hit, armed, take, release_evt;

    // Decide whether this cycle's hit is accepted and whether a deferred fire is due.
    always_comb begin
        hit         = |(cmp_match & cmp_sel);
        armed       = !status_q || restart_en;
        take        = hit && armed && !wr_en;
        release_evt = paused_q && !paused && pending_q;
    end

    // Update flags: a write wins, otherwise an accepted hit sets status (and pending if paused).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= 1'b0;
            pending_q <= 1'b0;
            fire_q    <= 1'b0;
            paused_q  <= 1'b0;
        end else begin
            paused_q <= paused;
            fire_q   <= (take && !paused) || release_evt;
            if (wr_en) begin
                status_q  <= wr_status;
                pending_q <= wr_pending;
            end else if (take) begin
                status_q <= 1'b1;
                if (paused) pending_q <= 1'b1;
            end
        end
    end

    assign status  = status_q;
    assign pending = pending_q;
    assign fire    = fire_q;

    assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !wr_en) |=> status_q);
    assert_no_refire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !restart_en && !(paused_q && !paused && pending_q)) |=> !fire_q);
    assert_restart_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && restart_en && !paused && !wr_en) |=> fire_q);
    assert_paused_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> !fire_q);
    assert_pending_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && armed && paused && !wr_en) |=> (pending_q && status_q));
    assert_release_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_q && !paused && pending_q) |=> fire_q);

endmodule

// File: rtl/oss_read_mux.sv
// Selects the addressed unit's flags and forms the 64-bit readback word.
// Assumes rd_ok already folds in strobe, index range and trace unit state.
module oss_read_mux
    import oss_pkg::*;
#(
    parameter int             NUM_UNITS   = 4,
    parameter logic [7:0]     PE_CAP_MASK = 8'h05
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] status,
    input  logic [NUM_UNITS-1:0] pending,
    input  logic                 rd_ok,
    input  logic [2:0]           reg_idx,
    output logic [WORD_W-1:0]    reg_rdata
);
    // Pick the addressed unit and gate the word with the read qualifier.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (rd_ok && reg_idx == 3'(i))
                reg_rdata = build_word(status[i], pending[i], PE_CAP_MASK[i]);
        end
    end

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[63:32] == '0) && (reg_rdata[29:4] == '0) && (reg_rdata[2:1] == 2'b00));
    assert_read_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> (reg_rdata == '0));
    assert_ia_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> reg_rdata[0]);

endmodule

// File: rtl/oneshot_status_bank.sv
// Top of the single-shot status bank: access decode, NUM_UNITS control units,
// and the readback mux. Assumes comparators and selection registers live
// outside and arrive as plain inputs.
module oneshot_status_bank
    import oss_pkg::*;
#(
    parameter int         NUM_UNITS   = 4,
    parameter int         NUM_CMP     = 4,
    parameter logic [7:0] PE_CAP_MASK = 8'h05
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CMP-1:0]           cmp_match,
    input  logic [NUM_UNITS*NUM_CMP-1:0] cmp_select,
    input  logic                         paused,
    input  logic [NUM_UNITS-1:0]         restart_en,
    input  logic [1:0]                   tu_state,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [2:0]                   reg_idx,
    input  logic [63:0]                  reg_wdata,
    output logic [NUM_UNITS-1:0]         fire,
    output logic [63:0]                  reg_rdata
);
    logic [NUM_UNITS-1:0] wr_vec;
    logic                 rd_ok;
    logic [NUM_UNITS-1:0] status_v;
    logic [NUM_UNITS-1:0] pending_v;
    logic                 unused_wdata;

    // Only the two flag bits of the write data are stored.
    assign unused_wdata = ^{reg_wdata[63:32], reg_wdata[29:0]};

    oss_access_decode #(.NUM_UNITS(NUM_UNITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .tu_state(tu_state), .wr_vec(wr_vec), .rd_ok(rd_ok)
    );

    generate
        for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
            oss_unit #(.NUM_CMP(NUM_CMP)) u_unit (
                .clk(clk), .rst_n(rst_n),
                .cmp_match(cmp_match),
                .cmp_sel(cmp_select[i*NUM_CMP +: NUM_CMP]),
                .paused(paused), .restart_en(restart_en[i]),
                .wr_en(wr_vec[i]),
                .wr_status(reg_wdata[BIT_STAT]), .wr_pending(reg_wdata[BIT_PEND]),
                .status(status_v[i]), .pending(pending_v[i]), .fire(fire[i])
            );
        end
    endgenerate

    oss_read_mux #(.NUM_UNITS(NUM_UNITS), .PE_CAP_MASK(PE_CAP_MASK)) u_rmux (
        .clk(clk), .rst_n(rst_n), .status(status_v), .pending(pending_v),
        .rd_ok(rd_ok), .reg_idx(reg_idx), .reg_rdata(reg_rdata)
    );

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (fire == '0 && status_v == '0 && pending_v == '0));

endmodule

// File: tb/oneshot_status_bank_tb.sv
// Directed sweeps over a 4-unit, 4-comparator bank; unit u selects comparators
// u and (u+1)%4, so every pulse hits two units.
module oneshot_status_bank_tb_top;
    localparam int         NU  = 4;
    localparam int         NC  = 4;
    localparam logic [7:0] PEM = 8'h05;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   cmp_match = '0;
    logic [NU*NC-1:0] cmp_select;
    logic            paused = 1'b0;
    logic [NU-1:0]   restart_en = '0;
    logic [1:0]      tu_state = 2'b00;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [2:0]      reg_idx = '0;
    logic [63:0]     reg_wdata = '0;
    logic [NU-1:0]   fire;
    logic [63:0]     reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    oneshot_status_bank #(.NUM_UNITS(NU), .NUM_CMP(NC), .PE_CAP_MASK(PEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .cmp_select(cmp_select),
        .paused(paused), .restart_en(restart_en), .tu_state(tu_state),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .fire(fire), .reg_rdata(reg_rdata)
    );

    function automatic logic [63:0] exp_word(int u, logic st, logic pd);
        logic [63:0] w = 64'd0;
        w[31] = st; w[30] = pd; w[3] = PEM[u]; w[0] = 1'b1;
        return w;
    endfunction

    function automatic logic [NU-1:0] units_hit(logic [NC-1:0] m);
        logic [NU-1:0] r = '0;
        for (int u = 0; u < NU; u++) r[u] = m[u % NC] | m[(u + 1) % NC];
        return r;
    endfunction

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_fire(string tag, logic [NU-1:0] exp);
        chk64(tag, 64'(fire), 64'(exp));
    endtask

    task automatic rd_chk(int idx, logic [63:0] exp, string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx[2:0];
        #1;
        chk64(tag, reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    task automatic wr(int idx, logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        for (int u = 0; u < NU; u++) wr(u, 64'd0);
    endtask

    task automatic hit(logic [NC-1:0] m, logic [NU-1:0] exp_f, string tag);
        @(negedge clk);
        cmp_match = m;
        @(negedge clk);
        cmp_match = '0;
        #1;
        chk_fire(tag, exp_f);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) begin
            cmp_select[u*NC +: NC] = '0;
            cmp_select[u*NC + (u % NC)] = 1'b1;
            cmp_select[u*NC + ((u + 1) % NC)] = 1'b1;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk_fire("R11 fire after reset", '0);
        rst_n = 1'b1;
        for (int u = 0; u < NU; u++) rd_chk(u, exp_word(u, 1'b0, 1'b0), "R11 R7 reset word");

        // R1: sweep each comparator alone; only selecting units fire and set status.
        for (int c = 0; c < NC; c++) begin
            logic [NU-1:0] ef;
            clear_all();
            ef = units_hit(NC'(1 << c));
            hit(NC'(1 << c), ef, "R1 first hit fire");
            for (int u = 0; u < NU; u++) rd_chk(u, exp_word(u, ef[u], 1'b0), "R1 status after hit");
        end

        // R3 / R2: single-shot mode disarms after the first hit.
        clear_all();
        hit(4'b0001, 4'b1001, "R3 first fire");
        hit(4'b0001, 4'b0000, "R3 no refire");
        repeat (5) @(negedge clk);
        rd_chk(0, exp_word(0, 1'b1, 1'b0), "R2 status sticky");
        rd_chk(3, exp_word(3, 1'b1, 1'b0), "R2 status sticky u3");

        // R4: restart mode fires on every hit, one cycle wide.
        restart_en = '1;
        hit(4'b0001, 4'b1001, "R4 refire 1");
        @(negedge clk); #1;
        chk_fire("R4 pulse one cycle", '0);
        hit(4'b0001, 4'b1001, "R4 refire 2");
        hit(4'b0100, 4'b0110, "R4 other comparator");
        restart_en = '0;

        // R5 / R6: hits under pause are deferred into one fire on release.
        clear_all();
        @(negedge clk); paused = 1'b1;
        hit(4'b0010, 4'b0000, "R5 no fire while paused");
        rd_chk(0, exp_word(0, 1'b1, 1'b1), "R5 pending u0");
        rd_chk(1, exp_word(1, 1'b1, 1'b1), "R5 pending u1");
        rd_chk(2, exp_word(2, 1'b0, 1'b0), "R5 unselected u2");
        hit(4'b0010, 4'b0000, "R5 second paused hit");
        @(negedge clk); paused = 1'b0;
        @(negedge clk); #1;
        chk_fire("R6 deferred fire", 4'b0011);
        @(negedge clk); #1;
        chk_fire("R6 single deferred pulse", 4'b0000);

        // R8: writes load the flag bits only; a write beats a same-cycle hit.
        wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(2, exp_word(2, 1'b1, 1'b1), "R8 write all ones");
        wr(2, 64'd0);
        rd_chk(2, exp_word(2, 1'b0, 1'b0), "R8 write zero");
        wr(1, 64'h0000_0000_8000_0000);
        rd_chk(1, exp_word(1, 1'b1, 1'b0), "R8 write status only");
        wr(1, 64'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'd1; reg_wdata = 64'd0; cmp_match = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; cmp_match = '0;
        #1;
        chk_fire("R8 write beats hit", 4'b0000);
        rd_chk(1, exp_word(1, 1'b0, 1'b0), "R8 write beats hit status");

        // R9: writes outside Idle or to an absent index do nothing.
        tu_state = 2'b10;
        wr(0, 64'd0);
        tu_state = 2'b01;
        wr(0, 64'd0);
        tu_state = 2'b00;
        rd_chk(0, exp_word(0, 1'b1, 1'b1), "R9 non-idle write ignored");
        wr(NU, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(7, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int u = 1; u < NU; u++) rd_chk(u, exp_word(u, 1'b0, 1'b0), "R9 bad index ignored");

        // R10: read gating by state, index and strobe.
        tu_state = 2'b11;
        rd_chk(0, 64'd0, "R10 read in other state");
        tu_state = 2'b10;
        rd_chk(0, 64'd0, "R10 read in busy state");
        tu_state = 2'b01;
        rd_chk(0, exp_word(0, 1'b1, 1'b1), "R10 read in stable");
        tu_state = 2'b00;
        rd_chk(6, 64'd0, "R10 read bad index");
        @(negedge clk); reg_rd = 1'b0; reg_idx = 3'd0; #1;
        chk64("R10 no strobe", reg_rdata, 64'd0);

        // R11: reset mid-run clears everything.
        @(negedge clk); rst_n = 1'b0;
        cmp_match = 4'b1111;
        repeat (2) @(negedge clk);
        #1;
        chk_fire("R11 fire held low in reset", '0);
        cmp_match = '0; rst_n = 1'b1;
        for (int u = 0; u < NU; u++) rd_chk(u, exp_word(u, 1'b0, 1'b0), "R11 cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule